// File: doc/BRIEF.md
# UART Receive Queue with Switchable Depth

This block is the receive-side character store of a UART. Characters arrive from the deserialiser as 12-bit words, with the 8-bit character in the low bits and the error bits above it. They are kept in a circular queue that holds 16 words when queueing is enabled and only one word when it is disabled. Switching the enable in either direction empties the queue. A line-break indication is stored as a special word with only bit 10 set.

The bus side pops words. The word at the head is visible on `rd_data` at all times. When a pop is applied, the error bits of that head word (bits 11:8) are copied into a status register, which a separate clear input zeroes. The block keeps the empty and full flags and a raw receive interrupt, which is driven against a trigger count that defaults to one word.

Top module: `uart_rx_queue`

## Requirements
- R1: Words leave in the order they were accepted. `rd_data` always shows the word at the read pointer. The write slot is (read pointer + count) modulo the depth, so the queue wraps around.
- R2: A push is accepted only while the count is below the capacity: 16 when the registered mode is queueing (`fifo_en` = 1) and 1 when it is not. A push beyond capacity is dropped. `can_accept` is high exactly when the count is below the capacity.
- R3: `rx_full` is 1 exactly when the count equals the capacity of the current mode. A pop that removes a word clears it.
- R4: `rx_empty` is 1 exactly when the count is zero. A push clears it, and a pop that leaves zero words sets it.
- R5: A pop while the queue is empty leaves the read pointer and the count unchanged. The head word still shows on `rd_data`.
- R6: A change of `fifo_en` from the value registered on the previous cycle resets the read pointer and the count to zero, sets `rx_empty`, and clears `rx_full` and `rx_irq`. A push or a pop in that cycle is ignored.
- R7: `brk_in` pushes the word 0x400 (bit 10 set, all other bits 0). It takes precedence over `push`/`push_data` in the same cycle.
- R8: On each pop (including a pop while the queue is empty, but not in a flush cycle), bits 11:8 of the head word are loaded into `rx_status`. `status_clr` zeroes `rx_status`. When both happen in the same cycle, the pop wins.
- R9: `rx_irq` is set when a push alone brings the count to the trigger level (default 1). It is cleared when a pop alone brings the count to the trigger level minus one.
- R10: When a push and a pop are both applied in the same cycle, the count stays the same, the read pointer advances, and the flags follow the resulting count.
- R11: After reset the count is 0, `rx_empty`=1, `rx_full`=0, `rx_irq`=0, `rx_status`=0, `rd_data`=0, and the registered mode is 0 (single word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Queueing enable (1 = 16 words, 0 = 1 word) |
| push | input | 1 | Store `push_data` |
| push_data | input | 12 | Received word: character in 7:0, error bits in 11:8 |
| brk_in | input | 1 | Store a break word (0x400) |
| pop | input | 1 | Remove the head word |
| status_clr | input | 1 | Zero the captured status |
| rd_data | output | 12 | Word at the read pointer |
| can_accept | output | 1 | Count is below the capacity |
| rx_empty | output | 1 | Queue empty flag |
| rx_full | output | 1 | Queue full flag |
| rx_irq | output | 1 | Raw receive interrupt |
| rx_status | output | 4 | Error bits of the last popped word |

## Verification
Directed sequences fill the queue past 16 words and then drain it. This shows whether wrap-around and drop-on-overflow behave correctly and whether `rx_full` tracks the capacity. It is repeated in single-word mode, so that a capacity fixed at 16 would show up. Pops on an empty queue, pushes and pops in the same cycle, and a break combined with ordinary data separate the stall, simultaneous-operation and priority rules. After that, a long seeded random mix of pushes, pops, breaks, clears and mode toggles is compared cycle by cycle against a reference queue in the bench. The mode toggles land at arbitrary fill levels, which tests that the flush ignores whatever operation shares its cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // Decoded operation applied to the queue in one cycle.
   typedef struct packed {
      logic flush;
      logic put;
      logic take;
   } rxq_op_t;

   // Number of low bits carrying the character itself.
   localparam int unsigned CHAR_W = 8;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 12,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_ptr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] slot_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[i] <= '0;
         end else if (wr_en && (wr_ptr == PTR_W'(i))) begin
            slot_q[i] <= wr_data;
         end
      end
   end

   assign rd_data = slot_q[rd_ptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned TRIG_LVL = 1,
   localparam int unsigned PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             put_req,
   input  logic             take_req,
   input  logic             fifo_en,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [PTR_W-1:0] wr_ptr,
   output logic             wr_en,
   output logic             take_fire,
   output logic             can_accept,
   output logic             rx_empty,
   output logic             rx_full,
   output logic             rx_irq
);
   import rxq_pkg::*;

   localparam logic [CNT_W-1:0] CAP_Q    = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CAP_1    = CNT_W'(1);
   localparam logic [CNT_W-1:0] TRIG     = CNT_W'(TRIG_LVL);
   localparam logic [CNT_W-1:0] TRIG_M1  = CNT_W'(TRIG_LVL - 1);

   logic [PTR_W-1:0] rptr_q;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             mode_q;
   logic [CNT_W-1:0] cap;
   rxq_op_t          op;
   logic             empty_q, full_q, irq_q;

   assign cap        = mode_q ? CAP_Q : CAP_1;
   assign can_accept = (cnt_q < cap);

   always_comb begin
      op.flush = (fifo_en != mode_q);
      op.put   = put_req  && !op.flush && can_accept;
      op.take  = take_req && !op.flush && (cnt_q != '0);
   end

   assign wr_en     = op.put;
   assign wr_ptr    = rptr_q + PTR_W'(cnt_q);
   assign take_fire = take_req && !op.flush;

   always_comb begin
      cnt_d = cnt_q;
      case ({op.put, op.take})
         2'b10:   cnt_d = cnt_q + CNT_W'(1);
         2'b01:   cnt_d = cnt_q - CNT_W'(1);
         default: cnt_d = cnt_q;
      endcase
   end

   // Pointer advance: power-of-two depth wraps naturally, a single entry stays at zero.
   logic [PTR_W-1:0] rptr_inc;
   if (DEPTH > 1) begin : g_ptr_wrap
      assign rptr_inc = rptr_q + PTR_W'(1);
   end else begin : g_ptr_fixed
      assign rptr_inc = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q  <= '0;
         cnt_q   <= '0;
         mode_q  <= 1'b0;
         empty_q <= 1'b1;
         full_q  <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         mode_q <= fifo_en;
         if (op.flush) begin
            rptr_q  <= '0;
            cnt_q   <= '0;
            empty_q <= 1'b1;
            full_q  <= 1'b0;
            irq_q   <= 1'b0;
         end else begin
            if (op.take) rptr_q <= rptr_inc;
            cnt_q   <= cnt_d;
            empty_q <= (cnt_d == '0);
            full_q  <= (cnt_d == cap);
            if (op.put && !op.take && (cnt_d == TRIG)) begin
               irq_q <= 1'b1;
            end else if (op.take && !op.put && (cnt_d == TRIG_M1)) begin
               irq_q <= 1'b0;
            end
         end
      end
   end

   assign rd_ptr   = rptr_q;
   assign rx_empty = empty_q;
   assign rx_full  = full_q;
   assign rx_irq   = irq_q;

   // R2: count never exceeds the capacity of the registered mode
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= cap);
   // R3: a full queue refuses input
   a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> !can_accept);
   // R4: empty and full never coexist
   a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_empty && rx_full));
   // R6: a mode change leaves an empty queue with no interrupt
   a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en != mode_q) |=> (rx_empty && !rx_full && !rx_irq));
   // R9: interrupt only while the count is at or above the trigger
   a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (cnt_q >= TRIG));
   // R5: a pop on an empty queue with no push keeps it empty
   a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_empty && take_req && !put_req && (fifo_en == mode_q)) |=> rx_empty);
endmodule

// File: rtl/rxq_stat.sv
module rxq_stat #(
   parameter int unsigned DATA_W = 12,
   localparam int unsigned ST_W  = DATA_W - rxq_pkg::CHAR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_fire,
   input  logic              clr,
   input  logic [DATA_W-1:0] head,
   output logic [ST_W-1:0]   status
);
   logic [ST_W-1:0] st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else if (take_fire) begin
         st_q <= head[DATA_W-1:rxq_pkg::CHAR_W];
      end else if (clr) begin
         st_q <= '0;
      end
   end

   assign status = st_q;

   // R8: a clear without a pop zeroes the status
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !take_fire) |=> (status == '0));
   // R8: status only moves on a pop or a clear
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !take_fire) |=> $stable(status));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned DATA_W   = 12,
   parameter int unsigned TRIG_LVL = 1,
   parameter int unsigned BRK_BIT  = 10,
   localparam int unsigned PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned ST_W    = DATA_W - rxq_pkg::CHAR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              brk_in,
   input  logic              pop,
   input  logic              status_clr,
   output logic [DATA_W-1:0] rd_data,
   output logic              can_accept,
   output logic              rx_empty,
   output logic              rx_full,
   output logic              rx_irq,
   output logic [ST_W-1:0]   rx_status
);
   localparam logic [DATA_W-1:0] BRK_WORD = DATA_W'(1) << BRK_BIT;

   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (TRIG_LVL < 1 || TRIG_LVL > DEPTH) begin : g_bad_trig
      $error("TRIG_LVL must lie in 1..DEPTH");
   end
   if (DATA_W <= BRK_BIT || DATA_W <= rxq_pkg::CHAR_W) begin : g_bad_width
      $error("DATA_W too narrow for break bit and status");
   end

   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic              wr_en, take_fire;
   logic [DATA_W-1:0] wr_word;

   assign wr_word = brk_in ? BRK_WORD : push_data;

   rxq_ctrl #(.DEPTH(DEPTH), .TRIG_LVL(TRIG_LVL)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .put_req    (push | brk_in),
      .take_req   (pop),
      .fifo_en    (fifo_en),
      .rd_ptr     (rd_ptr),
      .wr_ptr     (wr_ptr),
      .wr_en      (wr_en),
      .take_fire  (take_fire),
      .can_accept (can_accept),
      .rx_empty   (rx_empty),
      .rx_full    (rx_full),
      .rx_irq     (rx_irq)
   );

   rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_ptr  (wr_ptr),
      .wr_data (wr_word),
      .rd_ptr  (rd_ptr),
      .rd_data (rd_data)
   );

   rxq_stat #(.DATA_W(DATA_W)) i_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_fire (take_fire),
      .clr       (status_clr),
      .head      (rd_data),
      .status    (rx_status)
   );

   // R7: a break write stores exactly the break word
   a_r7_break_word: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_in && wr_en) |-> (wr_word == BRK_WORD));
endmodule

// File: tb/test_uart_rx_queue.sv
`timescale 1ns/1ps
module test_uart_rx_queue;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fifo_en = 1'b0, push = 1'b0, brk_in = 1'b0, pop = 1'b0, status_clr = 1'b0;
   logic [11:0] push_data = '0;
   logic [11:0] rd_data;
   logic        can_accept, rx_empty, rx_full, rx_irq;
   logic [3:0]  rx_status;

   always #2.5 clk = ~clk;

   uart_rx_queue i_uart_rx_queue (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push(push), .push_data(push_data),
      .brk_in(brk_in), .pop(pop), .status_clr(status_clr), .rd_data(rd_data),
      .can_accept(can_accept), .rx_empty(rx_empty), .rx_full(rx_full),
      .rx_irq(rx_irq), .rx_status(rx_status)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference queue
   logic [11:0] m_mem [16];
   int          m_rp = 0, m_cnt = 0;
   logic        m_mode = 0, m_empty = 1, m_full = 0, m_irq = 0;
   logic [3:0]  m_st = 0;

   function automatic int cap_of(logic mode);
      return mode ? 16 : 1;
   endfunction

   task automatic cmp(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_all(string tag);
      cmp({tag, "/R1"}, "rd_data", rd_data, m_mem[m_rp]);
      cmp({tag, "/R2"}, "can_accept", can_accept, m_cnt < cap_of(m_mode));
      cmp({tag, "/R3"}, "rx_full", rx_full, m_full);
      cmp({tag, "/R4"}, "rx_empty", rx_empty, m_empty);
      cmp({tag, "/R9"}, "rx_irq", rx_irq, m_irq);
      cmp({tag, "/R8"}, "rx_status", rx_status, m_st);
   endtask

   function automatic void model_step(logic fe, logic pu, logic [11:0] d, logic bk,
                                      logic po, logic cl);
      bit flush = (fe != m_mode);
      int cp = cap_of(m_mode);
      m_mode = fe;
      if (flush) begin
         m_rp = 0; m_cnt = 0; m_empty = 1; m_full = 0; m_irq = 0;
         if (cl) m_st = 0;
      end else begin
         bit pv = (pu || bk) && (m_cnt < cp);
         bit tv = po && (m_cnt > 0);
         logic [11:0] w = bk ? 12'h400 : d;
         if (po) m_st = m_mem[m_rp][11:8];
         else if (cl) m_st = 0;
         if (pv) m_mem[(m_rp + m_cnt) % 16] = w;
         if (tv) m_rp = (m_rp + 1) % 16;
         m_cnt = m_cnt + int'(pv) - int'(tv);
         if (pv && !tv && m_cnt == 1) m_irq = 1;
         else if (tv && !pv && m_cnt == 0) m_irq = 0;
         m_empty = (m_cnt == 0);
         m_full  = (m_cnt == cp);
      end
   endfunction

   // compare current state, then apply one cycle of stimulus
   task automatic cyc(string tag, logic fe, logic pu, logic [11:0] d, logic bk,
                      logic po, logic cl);
      @(negedge clk);
      check_all(tag);
      fifo_en = fe; push = pu; push_data = d; brk_in = bk; pop = po; status_clr = cl;
      model_step(fe, pu, d, bk, po, cl);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) m_mem[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      check_all("R11");
      cmp("R11", "rd_data", rd_data, 0);

      // R2/R3: single-word mode, second push dropped
      cyc("R2", 0, 1, 12'h0A5, 0, 0, 0);
      cyc("R2", 0, 1, 12'h0B6, 0, 0, 0);
      cyc("R3", 0, 0, 0, 0, 1, 0);
      cyc("R4", 0, 0, 0, 0, 0, 0);

      // R6: enable queueing (flush), fill past 16, drain in order
      cyc("R6", 1, 1, 12'h111, 0, 0, 0);
      for (int i = 0; i < 18; i++) cyc("R2", 1, 1, 12'(12'h300 + i), 0, 0, 0);
      cyc("R3", 1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 16; i++) cyc("R1", 1, 0, 0, 0, 1, 0);
      // R5: pops on empty queue
      cyc("R5", 1, 0, 0, 0, 1, 0);
      cyc("R5", 1, 0, 0, 0, 1, 0);
      // R7: break over data, then pop to capture status
      cyc("R7", 1, 1, 12'hFFF, 1, 0, 0);
      cyc("R7", 1, 1, 12'hE5A, 0, 0, 0);
      cyc("R8", 1, 0, 0, 0, 1, 0);
      cyc("R8", 1, 0, 0, 0, 1, 1);
      cyc("R8", 1, 0, 0, 0, 0, 1);
      // R10: simultaneous push and pop
      cyc("R10", 1, 1, 12'h9C3, 0, 0, 0);
      cyc("R10", 1, 1, 12'h8C4, 0, 1, 0);
      cyc("R10", 1, 1, 12'h7C5, 0, 1, 0);
      cyc("R10", 1, 0, 0, 0, 0, 0);
      // R6: toggle with push and pop pending mid-fill
      cyc("R6", 0, 1, 12'h055, 0, 1, 0);
      cyc("R6", 0, 0, 0, 0, 0, 0);

      // seeded random mix
      void'($urandom(32'h5EED));
      for (int i = 0; i < 4000; i++) begin
         logic fe = (($urandom % 40) == 0) ? ~fifo_en : fifo_en;
         int bias = (i / 500) % 2;
         logic pu = ($urandom % 100) < (bias ? 70 : 40);
         logic po = ($urandom % 100) < (bias ? 30 : 55);
         logic bk = ($urandom % 100) < 5;
         logic cl = ($urandom % 100) < 10;
         cyc("RND", fe, pu, 12'($urandom), bk, po, cl);
      end
      @(negedge clk);
      check_all("END");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule